// File: doc/BRIEF.md
# Pipeline Stall and Bubble Controller

This block is the hazard control of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It looks at the instruction class held in each stage, the source registers read in decode, the load destination in execute, and the branch-resolution flags. From these it produces one stall strobe and one bubble strobe for each pipeline register bank. A stalled bank keeps its contents. A bubbled bank loads the default nop contents at the next edge.

Three policies are folded together, and each has a fixed cost:
- A load whose result is needed by the very next instruction costs one cycle. The consumer waits in decode and a nop enters execute.
- A conditional jump that was predicted taken but resolves not taken costs two cycles. Both wrong-path instructions are flushed at the decode and execute inputs before either can touch the condition codes.
- A return costs three cycles. Fetch is frozen and nops are fed into decode until the return address leaves memory.

A halt reached through the misprediction-recovery fetch path is held by a separate strobe to the fetch address mux, not by freezing the predicted-PC bank.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Instruction classes are 4-bit codes: halt 0x0, nop 0x1, move 0x2, immediate 0x3, store 0x4, load 0x5, ALU 0x6, jump 0x7, call 0x8, return 0x9, push 0xA, pop 0xB. Register value 0xF means "no register". When there is no hazard, every stall and bubble bit is 0 and `keepFetchPc` is 0.
- R2: Load-use interlock. Execute holds a load (0x5) or a pop (0xB) whose `eDstM` is not 0xF and equals `dSrcA` or `dSrcB`, and no misprediction is being squashed. Then the fetch and decode banks stall and the execute bank is bubbled.
- R3: No interlock is raised in either of these cases:
  - `eDstM` is 0xF.
  - `eDstM` matches neither decode source.
  - The execute instruction is neither a load nor a pop, whatever its register fields.
- R4: Misprediction. Execute holds a jump (0x7) with `eMispredict`=1. Then the decode and execute banks are bubbled, and decode is not stalled.
- R5: `eMispredict` has no effect unless execute holds a jump.
- R6: A return (0x9) in execute or memory, or in decode when no squash is under way, stalls fetch and bubbles decode.
- R7: When a return in decode coincides with a load-use interlock, decode stalls rather than bubbles. Execute is bubbled and fetch stalls.
- R8: When a return in decode is on the wrong path of a mispredicted jump, it is squashed. Decode and execute are bubbled and fetch is not stalled.
- R9: A halt (0x0) in fetch stalls the fetch bank. The exception is when memory holds a jump (0x7) with `mMispredict`=1. In that case `keepFetchPc` is 1 and the fetch bank is not stalled.
- R10: Vector bit order is fetch=0, decode=1, execute=2, memory=3, writeback=4. No bank is stalled and bubbled at once, and `keepFetchPc` never coincides with a fetch stall. The memory and writeback banks are never stalled or bubbled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fIcode | input | 4 | Class of the instruction being fetched |
| dIcode | input | 4 | Class of the instruction in decode |
| dSrcA | input | 4 | First register read in decode (0xF none) |
| dSrcB | input | 4 | Second register read in decode (0xF none) |
| eIcode | input | 4 | Class of the instruction in execute |
| eDstM | input | 4 | Memory-result destination in execute (0xF none) |
| eMispredict | input | 1 | Jump in execute resolved not taken |
| mIcode | input | 4 | Class of the instruction in memory |
| mMispredict | input | 1 | Jump in memory was mispredicted (fetch uses recovery address) |
| stallVec | output | 5 | Per-bank stall strobes |
| bubbleVec | output | 5 | Per-bank bubble strobes |
| keepFetchPc | output | 1 | Make the next predicted PC repeat the current fetch address |

## Verification
Assertions evaluated whenever the inputs change cover four properties:
- No bank is ever both stalled and bubbled, and the fetch-hold strobe and the fetch stall are never raised together.
- A squash always flushes both decode and execute.
- An interlock always freezes fetch and decode while bubbling execute.

Only the bench's scenarios can show the policy outcomes:
- A wrong-path return is squashed rather than waited on.
- A return yields to a load-use interlock.
- A halt on the recovery path selects the hold strobe instead of a stall.
- A misprediction flag outside a jump, or an unmatched or absent load destination, leaves every strobe low.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  localparam int ICODE_W   = 4;
  localparam int NUM_BANKS = 5;
  localparam int BANK_F    = 0;
  localparam int BANK_D    = 1;
  localparam int BANK_E    = 2;
  localparam int BANK_M    = 3;
  localparam int BANK_W    = 4;

  localparam logic [ICODE_W-1:0] IC_HALT  = 4'h0;
  localparam logic [ICODE_W-1:0] IC_LOAD  = 4'h5;
  localparam logic [ICODE_W-1:0] IC_JUMP  = 4'h7;
  localparam logic [ICODE_W-1:0] IC_RET   = 4'h9;
  localparam logic [ICODE_W-1:0] IC_POP   = 4'hB;

  // strobes from the hazard detector to the policy logic
  typedef struct packed {
    logic loadUse;
    logic mispredict;
    logic recover;
    logic retDecode;
    logic retLater;
    logic fetchHalt;
  } hazStrobes_t;
endpackage

// File: rtl/hazard_detect.sv
module hazard_detect
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [ICODE_W-1:0] fIcode,
  input  logic [ICODE_W-1:0] dIcode,
  input  logic [REG_W-1:0]   dSrcA,
  input  logic [REG_W-1:0]   dSrcB,
  input  logic [ICODE_W-1:0] eIcode,
  input  logic [REG_W-1:0]   eDstM,
  input  logic               eMispredict,
  input  logic [ICODE_W-1:0] mIcode,
  input  logic               mMispredict,
  output hazStrobes_t        strobes
);
  localparam logic [REG_W-1:0] NO_REG = '1;

  logic eIsLoad;
  logic dstMatch;

  always_comb begin
    eIsLoad  = (eIcode == IC_LOAD) || (eIcode == IC_POP);
    dstMatch = (eDstM != NO_REG) && ((eDstM == dSrcA) || (eDstM == dSrcB));

    strobes.loadUse    = eIsLoad && dstMatch;
    strobes.mispredict = (eIcode == IC_JUMP) && eMispredict;
    strobes.recover    = (mIcode == IC_JUMP) && mMispredict;
    strobes.retDecode  = (dIcode == IC_RET);
    strobes.retLater   = (eIcode == IC_RET) || (mIcode == IC_RET);
    strobes.fetchHalt  = (fIcode == IC_HALT);
  end
endmodule

// File: rtl/hazard_policy.sv
module hazard_policy
  import pipe_hazard_pkg::*;
(
  input  hazStrobes_t          strobes,
  output logic [NUM_BANKS-1:0] stallVec,
  output logic [NUM_BANKS-1:0] bubbleVec,
  output logic                 keepFetchPc
);
  logic retLive;
  logic interlock;

  always_comb begin
    // a return in decode behind a mispredicted jump is wrong-path: squash wins
    retLive   = (strobes.retDecode && !strobes.mispredict) || strobes.retLater;
    interlock = strobes.loadUse && !strobes.mispredict;

    keepFetchPc = strobes.fetchHalt && strobes.recover;

    stallVec  = '0;
    bubbleVec = '0;

    stallVec[BANK_F] = !keepFetchPc &&
                       ((!strobes.mispredict && (interlock || retLive)) ||
                        (strobes.fetchHalt && !strobes.recover));
    stallVec[BANK_D] = interlock;
    // a stalled decode bank keeps the return; otherwise fill it with a nop
    bubbleVec[BANK_D] = strobes.mispredict || (retLive && !interlock);
    bubbleVec[BANK_E] = strobes.mispredict || interlock;
  end

  always_comb begin
    p_squash_flush_r4: assert (!strobes.mispredict ||
                               (bubbleVec[BANK_D] && bubbleVec[BANK_E] && !stallVec[BANK_D]))
      else $error("squash did not flush decode and execute");
    p_interlock_r2: assert (!interlock ||
                            (stallVec[BANK_F] && stallVec[BANK_D] && bubbleVec[BANK_E]))
      else $error("interlock strobes incomplete");
    p_halt_hold_r9: assert (!(keepFetchPc && stallVec[BANK_F]))
      else $error("fetch hold and fetch stall together");
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    always_comb begin
      p_no_stall_bubble_r10: assert (!(stallVec[b] && bubbleVec[b]))
        else $error("bank %0d stalled and bubbled", b);
    end
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [ICODE_W-1:0]   fIcode,
  input  logic [ICODE_W-1:0]   dIcode,
  input  logic [REG_W-1:0]     dSrcA,
  input  logic [REG_W-1:0]     dSrcB,
  input  logic [ICODE_W-1:0]   eIcode,
  input  logic [REG_W-1:0]     eDstM,
  input  logic                 eMispredict,
  input  logic [ICODE_W-1:0]   mIcode,
  input  logic                 mMispredict,
  output logic [NUM_BANKS-1:0] stallVec,
  output logic [NUM_BANKS-1:0] bubbleVec,
  output logic                 keepFetchPc
);
  hazStrobes_t strobes;

  hazard_detect #(.REG_W(REG_W)) uDetect (
    .fIcode(fIcode), .dIcode(dIcode), .dSrcA(dSrcA), .dSrcB(dSrcB),
    .eIcode(eIcode), .eDstM(eDstM), .eMispredict(eMispredict),
    .mIcode(mIcode), .mMispredict(mMispredict), .strobes(strobes)
  );

  hazard_policy uPolicy (
    .strobes(strobes), .stallVec(stallVec), .bubbleVec(bubbleVec),
    .keepFetchPc(keepFetchPc)
  );
endmodule

// File: tb/pipe_hazard_ctrl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] fIcode, dIcode, dSrcA, dSrcB, eIcode, eDstM, mIcode;
  logic       eMispredict, mMispredict;
  logic [4:0] stallVec, bubbleVec;
  logic       keepFetchPc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pipe_hazard_ctrl uut (.*);

  // expected {stall[4:0], bubble[4:0], keep}
  function automatic logic [10:0] model(
      logic [3:0] f, logic [3:0] d, logic [3:0] sa, logic [3:0] sb,
      logic [3:0] e, logic [3:0] dm, logic emp, logic [3:0] m, logic mmp);
    logic [4:0] s = 5'b0;
    logic [4:0] b = 5'b0;
    logic k = 1'b0;
    bit mp = (e == 4'h7) && emp;
    bit rc = (m == 4'h7) && mmp;
    bit lu = (e == 4'h5 || e == 4'hB) && dm != 4'hF && (dm == sa || dm == sb);
    bit rt = (d == 4'h9 && !mp) || e == 4'h9 || m == 4'h9;
    if (f == 4'h0 && rc) k = 1'b1;
    else begin
      if (f == 4'h0) s[0] = 1'b1;
      if (!mp && (lu || rt)) s[0] = 1'b1;
    end
    if (mp) begin b[1] = 1'b1; b[2] = 1'b1; end
    else if (lu) begin s[1] = 1'b1; b[2] = 1'b1; end
    else if (rt) b[1] = 1'b1;
    return {s, b, k};
  endfunction

  task automatic apply(string tag, logic [3:0] f, logic [3:0] d, logic [3:0] sa,
                       logic [3:0] sb, logic [3:0] e, logic [3:0] dm, logic emp,
                       logic [3:0] m, logic mmp);
    logic [10:0] exp, act;
    @(negedge clk);
    fIcode = f; dIcode = d; dSrcA = sa; dSrcB = sb; eIcode = e; eDstM = dm;
    eMispredict = emp; mIcode = m; mMispredict = mmp;
    #2;
    exp = model(f, d, sa, sb, e, dm, emp, m, mmp);
    act = {stallVec, bubbleVec, keepFetchPc};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got stall=%b bubble=%b keep=%b expected stall=%b bubble=%b keep=%b",
               tag, act[10:6], act[5:1], act[0], exp[10:6], exp[5:1], exp[0]);
    end
    // R10 invariants at the ports
    checks++;
    if ((stallVec & bubbleVec) != 5'b0 || (keepFetchPc && stallVec[0]) ||
        stallVec[4:3] != 2'b0 || bubbleVec[4:3] != 2'b0) begin
      fails++;
      $display("FAIL R10 (%s): stall=%b bubble=%b keep=%b expected disjoint, M/W zero",
               tag, stallVec, bubbleVec, keepFetchPc);
    end
  endtask

  task automatic expectVec(string tag, logic [4:0] s, logic [4:0] b, logic k);
    checks++;
    if (stallVec !== s || bubbleVec !== b || keepFetchPc !== k) begin
      fails++;
      $display("FAIL %s: got %b/%b/%b expected %b/%b/%b", tag,
               stallVec, bubbleVec, keepFetchPc, s, b, k);
    end
  endtask

  initial begin
    // idle pipeline of nops
    apply("R1 idle", 4'h1, 4'h1, 4'hF, 4'hF, 4'h1, 4'hF, 0, 4'h1, 0);
    expectVec("R1 idle literal", 5'b0, 5'b0, 0);
    apply("R1 alu chain", 4'h6, 4'h6, 4'h1, 4'h2, 4'h6, 4'hF, 0, 4'h3, 0);
    // R2 load-use
    apply("R2 load srcA", 4'h6, 4'h6, 4'h3, 4'h1, 4'h5, 4'h3, 0, 4'h1, 0);
    expectVec("R2 literal", 5'b00011, 5'b00100, 0);
    apply("R2 pop srcB", 4'h1, 4'h6, 4'h1, 4'h4, 4'hB, 4'h4, 0, 4'h1, 0);
    // R3 no interlock
    apply("R3 none dst", 4'h1, 4'h6, 4'hF, 4'hF, 4'h5, 4'hF, 0, 4'h1, 0);
    expectVec("R3 none dst literal", 5'b0, 5'b0, 0);
    apply("R3 mismatch", 4'h1, 4'h6, 4'h1, 4'h2, 4'h5, 4'h3, 0, 4'h1, 0);
    apply("R3 non-load", 4'h1, 4'h6, 4'h3, 4'h3, 4'h6, 4'h3, 0, 4'h1, 0);
    expectVec("R3 non-load literal", 5'b0, 5'b0, 0);
    // R4 misprediction
    apply("R4 squash", 4'h6, 4'h6, 4'h1, 4'h2, 4'h7, 4'hF, 1, 4'h6, 0);
    expectVec("R4 literal", 5'b0, 5'b00110, 0);
    // R5 flag outside a jump
    apply("R5 flag ignored", 4'h6, 4'h6, 4'h1, 4'h2, 4'h6, 4'hF, 1, 4'h1, 0);
    expectVec("R5 literal", 5'b0, 5'b0, 0);
    apply("R5 jump taken ok", 4'h6, 4'h6, 4'h1, 4'h2, 4'h7, 4'hF, 0, 4'h1, 0);
    // R6 return hazard in each stage
    apply("R6 ret decode", 4'h1, 4'h9, 4'h4, 4'h4, 4'h1, 4'hF, 0, 4'h1, 0);
    expectVec("R6 literal", 5'b00001, 5'b00010, 0);
    apply("R6 ret execute", 4'h1, 4'h1, 4'hF, 4'hF, 4'h9, 4'hF, 0, 4'h1, 0);
    apply("R6 ret memory", 4'h1, 4'h1, 4'hF, 4'hF, 4'h1, 4'hF, 0, 4'h9, 0);
    // R7 return waits behind a load of the stack pointer
    apply("R7 ret+loaduse", 4'h1, 4'h9, 4'h4, 4'h4, 4'hB, 4'h4, 0, 4'h1, 0);
    expectVec("R7 literal", 5'b00011, 5'b00100, 0);
    // R8 wrong-path return squashed
    apply("R8 ret squashed", 4'h1, 4'h9, 4'h4, 4'h4, 4'h7, 4'hF, 1, 4'h1, 0);
    expectVec("R8 literal", 5'b0, 5'b00110, 0);
    // R9 halt handling
    apply("R9 halt stall", 4'h0, 4'h1, 4'hF, 4'hF, 4'h1, 4'hF, 0, 4'h1, 0);
    expectVec("R9 stall literal", 5'b00001, 5'b0, 0);
    apply("R9 halt recovery", 4'h0, 4'h1, 4'hF, 4'hF, 4'h1, 4'hF, 0, 4'h7, 1);
    expectVec("R9 keep literal", 5'b0, 5'b0, 1);
    apply("R9 jump ok in M", 4'h0, 4'h1, 4'hF, 4'hF, 4'h1, 4'hF, 0, 4'h7, 0);
    apply("R9 recovery no halt", 4'h6, 4'h1, 4'hF, 4'hF, 4'h1, 4'hF, 0, 4'h7, 1);
    expectVec("R9 recovery no halt literal", 5'b0, 5'b0, 0);

    // R10 plus all rules: constrained random mix, fixed seed
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      logic [3:0] rf, rd, ra, rb, re, rdm, rm;
      rf  = 4'($urandom_range(0, 11));
      rd  = 4'($urandom_range(0, 11));
      re  = 4'($urandom_range(0, 11));
      rm  = 4'($urandom_range(0, 11));
      ra  = 4'($urandom_range(0, 15));
      rb  = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom_range(0, 7));
      rdm = ($urandom_range(0, 1) == 0) ? ra : 4'($urandom_range(0, 15));
      apply("R10 random", rf, rd, ra, rb, re, rdm, 1'($urandom_range(0, 1)),
            rm, 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule